// File: doc/BRIEF.md
# Rectification Source-Coordinate Generator

This block walks a rectified output image in raster order and, for every output pixel, produces the location in the raw camera image that the pixel should be sampled from. It does not receive absolute addresses. Each incoming 8-bit table entry gives only the small signed step, in quarter-pixel units, from the previous output pixel's source location to this one. The block adds these steps into running X and Y accumulators. At the first pixel of each row it starts from an absolute seed coordinate given on dedicated inputs.

Entries arrive on a valid/ready stream. Each entry carries a frame-start flag and a row-end flag. The resulting fixed-point coordinates leave on a valid/ready stream one cycle later, with the same flags attached. The image is 752 columns by 480 rows by default. A coordinate that falls outside the image is clamped to the nearest edge and flagged. The running total keeps its true value, so a row can drift outside the image and come back.

Top module: `rect_coord_gen`

## Requirements
- R1: An entry's bits [7:4] are the X step and bits [3:0] the Y step. Each step is a 4-bit two's-complement count of quarter pixels, so 4'b1000 is -2.00 and 4'b0111 is +1.75.
- R2: The source coordinate of a row-first pixel is its seed plus its own step. A pixel is row-first if it is the first entry accepted after reset, the first entry after an entry with the row-end flag, or any entry carrying the frame-start flag. Seeds are read only for row-first pixels.
- R3: The source coordinate of any other pixel is the previous pixel's unclamped coordinate plus its step. Coordinates are unsigned with 2 fractional bits (bits [1:0] are quarter pixels), and the fraction is never discarded.
- R4: `out_valid` is high in the cycle after an entry is accepted. While `out_valid` is high and `out_ready` is low, every output stays unchanged.
- R5: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. Every accepted entry yields exactly one output transfer, in order, with none lost or repeated.
- R6: `out_oob` is 1 when the X coordinate is below 0 or above (IMG_W-1)*4, or the Y coordinate is below 0 or above (IMG_H-1)*4. An out-of-range coordinate is clamped to 0 or to that maximum. The running total is not clamped or wrapped; it saturates only at the limits of its own two's-complement width, which is two bits wider than the output.
- R7: `out_sof` and `out_eol` carry the frame-start and row-end flags of the entry that produced the coordinate.
- R8: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Table entry present |
| in_ready | output | 1 | Block can take an entry |
| in_entry | input | 8 | Packed X/Y step |
| in_sof | input | 1 | Entry is the first of a frame |
| in_eol | input | 1 | Entry is the last of a row |
| seed_x | input | XW (12) | Row start X, fixed point with 2 fraction bits |
| seed_y | input | YW (11) | Row start Y, fixed point with 2 fraction bits |
| out_valid | output | 1 | Coordinate present |
| out_ready | input | 1 | Consumer takes the coordinate |
| out_x | output | XW (12) | Clamped source X |
| out_y | output | YW (11) | Clamped source Y |
| out_oob | output | 1 | Coordinate lies outside the image |
| out_sof | output | 1 | Forwarded frame-start flag |
| out_eol | output | 1 | Forwarded row-end flag |

## Verification
The hardest case to reach is a row whose running total leaves the image and then returns. The flag and the clamp must appear while the total is outside, and the following in-range coordinate must come from the unclamped total, not from the clamped output. Directed rows are seeded exactly at 0 and at the far edge, with steps that cross the boundary and then cross back, and some of these are held under output stalls. Random traffic changes the seeds every cycle and applies random backpressure, which shows whether seeds are ignored mid-row and whether stalls ever drop or repeat an entry.

// File: rtl/rect_pkg.sv
package rect_pkg;
  localparam int FRAC_BITS = 2;
  localparam int STEP_W    = 4;
  localparam int ENTRY_W   = 2 * STEP_W;

  // width of an unsigned fixed-point coordinate spanning n_pix pixels
  function automatic int coord_w(input int n_pix);
    return $clog2(n_pix) + FRAC_BITS;
  endfunction

  // largest in-image coordinate, in quarter pixels
  function automatic int coord_max(input int n_pix);
    return (n_pix - 1) << FRAC_BITS;
  endfunction

  function automatic logic signed [STEP_W-1:0] step_of_x(input logic [ENTRY_W-1:0] e);
    return $signed(e[ENTRY_W-1:STEP_W]);
  endfunction

  function automatic logic signed [STEP_W-1:0] step_of_y(input logic [ENTRY_W-1:0] e);
    return $signed(e[STEP_W-1:0]);
  endfunction
endpackage

// File: rtl/rect_step_unpack.sv
module rect_step_unpack
  import rect_pkg::*;
(
  input  logic [ENTRY_W-1:0]       entry,
  output logic signed [STEP_W-1:0] step_x,
  output logic signed [STEP_W-1:0] step_y
);
  assign step_x = step_of_x(entry);
  assign step_y = step_of_y(entry);
endmodule

// File: rtl/rect_axis_acc.sv
module rect_axis_acc
  import rect_pkg::*;
#(
  parameter int CW   = 12,
  parameter int MAXV = 3004
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic                     take_seed,
  input  logic [CW-1:0]            seed,
  input  logic signed [STEP_W-1:0] step,
  output logic signed [CW+1:0]     acc,
  output logic [CW-1:0]            coord,
  output logic                     oob
);
  localparam int AW = CW + 2;
  localparam logic signed [AW-1:0] MAX_S = AW'(MAXV);
  localparam logic signed [AW-1:0] POS_LIM = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] NEG_LIM = {1'b1, {(AW-1){1'b0}}};

  function automatic logic signed [AW-1:0] sat_add(
    input logic signed [AW-1:0]     a,
    input logic signed [STEP_W-1:0] d
  );
    logic signed [AW:0] wide;
    wide = {a[AW-1], a} + {{(AW+1-STEP_W){d[STEP_W-1]}}, d};
    if (wide[AW] != wide[AW-1]) return wide[AW] ? NEG_LIM : POS_LIM;
    return wide[AW-1:0];
  endfunction

  logic signed [AW-1:0] base;
  logic signed [AW-1:0] nxt;

  assign base = take_seed ? $signed({2'b00, seed}) : acc;
  assign nxt  = sat_add(base, step);

  always_ff @(posedge clk) begin
    if (!rst_n)   acc <= '0;
    else if (upd) acc <= nxt;
  end

  logic below, above;
  assign below = acc < 0;
  assign above = acc > MAX_S;
  assign oob   = below | above;
  assign coord = below ? '0 : (above ? MAX_S[CW-1:0] : acc[CW-1:0]);
endmodule

// File: rtl/rect_stream_ctl.sv
module rect_stream_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sof,
  input  logic in_eol,
  input  logic out_ready,
  output logic in_ready,
  output logic accept,
  output logic take_seed,
  output logic out_valid,
  output logic out_sof,
  output logic out_eol
);
  logic row_first;

  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign take_seed = row_first || in_sof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_first <= 1'b1;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else if (accept) begin
      row_first <= in_eol;
      out_valid <= 1'b1;
      out_sof   <= in_sof;
      out_eol   <= in_eol;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rect_coord_gen.sv
module rect_coord_gen
  import rect_pkg::*;
#(
  parameter int IMG_W = 752,
  parameter int IMG_H = 480,
  localparam int XW   = coord_w(IMG_W),
  localparam int YW   = coord_w(IMG_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_entry,
  input  logic          in_sof,
  input  logic          in_eol,
  input  logic [XW-1:0] seed_x,
  input  logic [YW-1:0] seed_y,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [XW-1:0] out_x,
  output logic [YW-1:0] out_y,
  output logic          out_oob,
  output logic          out_sof,
  output logic          out_eol
);
  localparam int XMAX = coord_max(IMG_W);
  localparam int YMAX = coord_max(IMG_H);

  // named internal events, observed by the bound checker
  logic accept;
  logic take_seed;
  logic signed [STEP_W-1:0] dx, dy;
  logic signed [XW+1:0] acc_x;
  logic signed [YW+1:0] acc_y;
  logic oob_x, oob_y;

  rect_step_unpack u_unpack (
    .entry  (in_entry),
    .step_x (dx),
    .step_y (dy)
  );

  rect_stream_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eol    (in_eol),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .accept    (accept),
    .take_seed (take_seed),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eol   (out_eol)
  );

  rect_axis_acc #(.CW(XW), .MAXV(XMAX)) u_acc_x (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (accept),
    .take_seed (take_seed),
    .seed      (seed_x),
    .step      (dx),
    .acc       (acc_x),
    .coord     (out_x),
    .oob       (oob_x)
  );

  rect_axis_acc #(.CW(YW), .MAXV(YMAX)) u_acc_y (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (accept),
    .take_seed (take_seed),
    .seed      (seed_y),
    .step      (dy),
    .acc       (acc_y),
    .coord     (out_y),
    .oob       (oob_y)
  );

  assign out_oob = oob_x | oob_y;
endmodule

// File: rtl/rect_coord_gen_chk.sv
module rect_coord_gen_chk #(
  parameter int XW = 12,
  parameter int YW = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 accept,
  input logic                 take_seed,
  input logic                 in_ready,
  input logic                 in_sof,
  input logic                 in_eol,
  input logic [XW-1:0]        seed_x,
  input logic signed [3:0]    dx,
  input logic signed [XW+1:0] acc_x,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [XW-1:0]        out_x,
  input logic [YW-1:0]        out_y,
  input logic                 out_oob,
  input logic                 out_sof,
  input logic                 out_eol
);
  logic signed [XW+1:0] seed_sx;
  assign seed_sx = $signed({2'b00, seed_x});

  p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && take_seed |=> acc_x == $past(seed_sx) + $past(dx));

  p_sof_is_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_sof |-> take_seed);

  p_step_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !take_seed && acc_x < 4096 && acc_x > -4096
    |=> acc_x == $past(acc_x) + $past(dx));

  p_valid_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y)
      && $stable(out_oob) && $stable(out_sof) && $stable(out_eol));

  p_ready_only_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  p_clamp_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && acc_x < 0 |-> out_oob && out_x == '0);

  p_markers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_sof == $past(in_sof) && out_eol == $past(in_eol));

  p_reset_idle_r8: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind rect_coord_gen rect_coord_gen_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .take_seed (take_seed),
  .in_ready  (in_ready),
  .in_sof    (in_sof),
  .in_eol    (in_eol),
  .seed_x    (seed_x),
  .dx        (dx),
  .acc_x     (acc_x),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_x     (out_x),
  .out_y     (out_y),
  .out_oob   (out_oob),
  .out_sof   (out_sof),
  .out_eol   (out_eol)
);

// File: tb/tb_rect_coord_gen.sv
module tb_rect_coord_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W = 752, H = 480;
  localparam int XW = 12, YW = 11;
  localparam int XMAX = (W - 1) * 4, YMAX = (H - 1) * 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eol = 0, out_ready = 0;
  logic [7:0] in_entry = 0;
  logic [XW-1:0] seed_x = 0;
  logic [YW-1:0] seed_y = 0;
  logic in_ready, out_valid, out_oob, out_sof, out_eol;
  logic [XW-1:0] out_x;
  logic [YW-1:0] out_y;

  rect_coord_gen dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int x; int y; bit oob; bit sof; bit eol; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  int mx = 0, my = 0;
  bit first = 1;
  bit prev_accept = 0;

  function automatic int nib(input logic [3:0] n);
    return (n >= 8) ? int'(n) - 16 : int'(n);
  endfunction
  function automatic int sat(input int v, input int bits);
    int lim = 1 << (bits - 1);
    if (v > lim - 1) return lim - 1;
    if (v < -lim) return -lim;
    return v;
  endfunction
  function automatic int clampv(input int v, input int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, observe, update model, advance
  task automatic step(input bit iv, input logic [7:0] e, input bit sof, input bit eol,
                      input int sx, input int sy, input bit ordy);
    exp_t ex;
    in_valid = iv; in_entry = e; in_sof = sof; in_eol = eol;
    seed_x = XW'(sx); seed_y = YW'(sy); out_ready = ordy;
    #1;
    if (prev_accept) chk(out_valid === 1'b1, "R4 valid after accept", out_valid, 1);
    chk(in_ready === !(out_valid && !out_ready), "R5 ready", in_ready, !(out_valid && !out_ready));
    if (out_valid && out_ready) begin
      if (q.size() == 0) chk(0, "R5 extra output", 1, 0);
      else begin
        ex = q.pop_front();
        chk(int'(out_x) == ex.x && int'(out_y) == ex.y, "R2/R3 coordinate",
            int'(out_x) * 10000 + int'(out_y), ex.x * 10000 + ex.y);
        chk(out_oob == ex.oob, "R6 oob", out_oob, ex.oob);
        chk(out_sof == ex.sof && out_eol == ex.eol, "R7 markers",
            {out_sof, out_eol}, {ex.sof, ex.eol});
      end
    end
    prev_accept = iv && in_ready;
    if (prev_accept) begin
      // R1: upper nibble X, lower nibble Y, quarter-pixel two's complement
      if (first || sof) begin mx = sx + nib(e[7:4]); my = sy + nib(e[3:0]); end
      else begin mx = mx + nib(e[7:4]); my = my + nib(e[3:0]); end
      mx = sat(mx, XW + 2); my = sat(my, YW + 2);
      first = eol;
      ex.x = clampv(mx, XMAX); ex.y = clampv(my, YMAX);
      ex.oob = (mx < 0) || (mx > XMAX) || (my < 0) || (my > YMAX);
      ex.sof = sof; ex.eol = eol;
      q.push_back(ex);
    end
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R8 reset valid", out_valid, 0);
    chk(in_ready === 1'b1, "R8 reset ready", in_ready, 1);
    rst_n = 1;
    @(negedge clk);
    // R1 nibble order and sign: +0.25 X, -0.25 Y on a row-first pixel (R2)
    step(1, 8'h1F, 1, 0, 400, 200, 1);
    step(1, 8'h80, 0, 0, 7, 7, 1);            // R1 -2.00 in X, seed ignored (R3)
    step(1, 8'h70, 0, 1, 9, 9, 1);            // R1 +1.75 in X, row end
    // R6 leave the image at 0 and return
    step(1, 8'hFF, 0, 0, 0, 0, 1);
    step(1, 8'h22, 0, 0, 99, 99, 1);
    step(1, 8'h80, 0, 1, 0, 0, 1);
    // R6 far edges, under a stall (R4/R5)
    step(1, 8'h11, 0, 0, XMAX, YMAX, 0);
    step(1, 8'hF0, 0, 0, 0, 0, 0);
    step(1, 8'hF0, 0, 0, 0, 0, 0);
    step(1, 8'hFF, 0, 1, 0, 0, 1);
    step(0, 8'h00, 0, 0, 0, 0, 1);
    // R2 frame start mid-row forces a reseed
    step(1, 8'h00, 0, 0, 123, 45, 1);
    step(1, 8'h00, 1, 0, 888, 777, 1);
    step(0, 8'h00, 0, 0, 0, 0, 1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 8;
      int sx = (r == 0) ? 0 : (r == 1) ? XMAX : int'($urandom % (XMAX + 1));
      int sy = (r == 0) ? 0 : (r == 1) ? YMAX : int'($urandom % (YMAX + 1));
      step(($urandom % 4) != 0, 8'($urandom), ($urandom % 64) == 0,
           ($urandom % 12) == 0, sx, sy, ($urandom % 5) != 0);
    end
    for (int i = 0; i < 4; i++) step(0, 8'h00, 0, 0, 0, 0, 1);
    chk(q.size() == 0, "R5 all entries delivered", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule